// File: doc/BRIEF.md
# Ingress Differential Queue-Length Inserter

This block sits on the ingress side of one port of an input-buffered cell switch that keeps one queue per virtual circuit (VC). Cells arrive as a stream of 53 bytes, each cell tagged with a VC index. The block keeps a live occupancy count for every VC. Accepted cells add one to the count of their VC. A separate dequeue strobe from the cell store removes one.

The block stamps forward resource-management (RM) cells with a signed 16-bit value. That value is the change in the VC's occupancy since the previous stamped RM cell of the same VC. After stamping, the block stores the current count as the new reference. The egress side of the output port can then sum these values to rebuild one aggregate queue length, with no per-VC table. After stamping, the block regenerates the CRC-10 of the RM cell.

Backward RM cells are flagged for the feedback path and are not counted. The block handles every cell store-and-forward. It drops a cell bound for a full VC queue, and a dropped RM cell changes nothing.

Top module: `dqi_ingress`

## Requirements
- R1: The block accepts a byte when `in_valid_i` and `ready_o` are both high, 53 bytes to a cell, and takes `in_vc_i` with byte 0. A kept cell leaves as 53 back-to-back bytes, with `out_sop_o` on byte 0 and `out_eop_o` on byte 52. `ready_o` stays low from the cycle after the last input byte until the output cell has ended.
- R2: A cell counts as an RM cell only if both of these hold. Bits 3:1 of cell byte 3 equal 3'b110. The CRC-10 (polynomial 0x233, register starting at zero, MSB first) over cell bytes 5..50 equals the 10-bit field formed by bits 1:0 of byte 51 and all of byte 52.
- R3: A non-RM cell leaves unmodified and counts as an enqueue on its VC. An RM cell with a bad CRC is a non-RM cell.
- R4: A forward RM cell has bit 7 of cell byte 6 equal to 0. It carries D = count(VC) − ref(VC) as 16-bit two's complement, with the high byte in cell byte 21 and the low byte in cell byte 22. Count is the occupancy before this cell is added.
- R5: When a forward RM cell is kept, ref(VC) takes the count used for D. The cell itself is then enqueued.
- R6: In a stamped cell, the CRC-10 over the modified bytes 5..50 replaces bits 1:0 of byte 51 and all of byte 52. Bits 7:2 of byte 51 are unchanged.
- R7: A backward RM cell has bit 7 of cell byte 6 equal to 1. It leaves unmodified with `out_fb_o` high. It is never dropped and does not change the count.
- R8: A non-backward cell whose VC count equals `Q_DEPTH` is dropped. Nothing is emitted, the count is unchanged and ref(VC) is unchanged.
- R9: `deq_i` lowers the count of `deq_vc_i` by one. An enqueue and a dequeue of the same VC on the same edge leave the count unchanged, and D uses the count before that edge.
- R10: A dequeue of a VC whose count is zero is ignored.
- R11: After reset, `ready_o` is high, `out_valid_o` is low, and all counts and references are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input cell byte |
| in_vc_i | input | VC_W | VC of the cell, taken with byte 0 |
| ready_o | output | 1 | Block can take an input byte |
| deq_i | input | 1 | One cell left a VC queue |
| deq_vc_i | input | VC_W | VC of the dequeue |
| out_valid_o | output | 1 | Output byte valid |
| out_sop_o | output | 1 | First byte of output cell |
| out_eop_o | output | 1 | Last byte of output cell |
| out_data_o | output | 8 | Output cell byte |
| out_vc_o | output | VC_W | VC of the output cell |
| out_fb_o | output | 1 | Cell is a backward RM cell for the feedback path |

## Verification
The hardest case to reach is a dequeue landing on the same edge as the enqueue decision of a cell. The bench has to place the strobe in the single cycle between the last accepted byte and the decision edge. It does this by raising `deq_i` at the falling edge that follows the final byte. Filling a VC to `Q_DEPTH` also takes work. The bench lowers `Q_DEPTH` to a handful of cells, so a few data cells reach the full state. It then sends a forward RM cell that must be dropped. A later dequeue and RM cell show that the reference held through the drop.

// File: rtl/dqi_pkg.sv
package dqi_pkg;
  localparam int CELL_LEN   = 53;
  localparam int IDX_W      = 6;
  localparam int PTI_BYTE   = 3;
  localparam int DIR_BYTE   = 6;
  localparam int CRC_FIRST  = 5;
  localparam int CRC_LAST   = 50;
  localparam int STAMP_HI   = 21;
  localparam int STAMP_LO   = 22;
  localparam int CRC_HI     = 51;
  localparam int CRC_LO     = 52;
  localparam logic [2:0] PTI_RM  = 3'b110;
  localparam logic [9:0] CRC_POLY = 10'h233;

  typedef logic [IDX_W-1:0] idx_t;
  typedef enum logic [1:0] {ST_RX, ST_DEC, ST_TX} st_e;

  function automatic logic [9:0] crc10_byte(logic [9:0] c, logic [7:0] b);
    logic [9:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[9] ^ b[i];
      r  = {r[8:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/dqi_cell_buf.sv
module dqi_cell_buf
  import dqi_pkg::*;
(
  input  logic        clk_i,
  input  logic        wr_en_i,
  input  idx_t        wr_idx_i,
  input  logic [7:0]  wr_data_i,
  input  logic        patch_en_i,
  input  logic [15:0] patch_word_i,
  input  idx_t        rd_idx_i,
  output logic [7:0]  rd_data_o
);
  logic [7:0] mem_q [CELL_LEN];

  for (genvar g = 0; g < CELL_LEN; g++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == idx_t'(g)) mem_q[g] <= wr_data_i;
      else if (patch_en_i && g == STAMP_HI) mem_q[g] <= patch_word_i[15:8];
      else if (patch_en_i && g == STAMP_LO) mem_q[g] <= patch_word_i[7:0];
    end
  end

  assign rd_data_o = (int'(rd_idx_i) < CELL_LEN) ? mem_q[rd_idx_i] : 8'h00;
endmodule

// File: rtl/dqi_vc_counters.sv
module dqi_vc_counters #(
  parameter int NUM_VC  = 16,
  parameter int QL_W    = 15,
  parameter int Q_DEPTH = (1 << QL_W) - 1,
  localparam int VC_W   = $clog2(NUM_VC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enq_i,
  input  logic            smp_i,
  input  logic [VC_W-1:0] rd_vc_i,
  input  logic            deq_i,
  input  logic [VC_W-1:0] deq_vc_i,
  output logic [QL_W-1:0] cnt_o,
  output logic [QL_W-1:0] ref_o,
  output logic            full_o
);
  logic [QL_W-1:0] cnt_q [NUM_VC];
  logic [QL_W-1:0] ref_q [NUM_VC];

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic inc, dec;
    assign inc = enq_i && rd_vc_i == VC_W'(v);
    assign dec = deq_i && deq_vc_i == VC_W'(v);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[v] <= '0;
        ref_q[v] <= '0;
      end else begin
        if (inc && !dec) cnt_q[v] <= cnt_q[v] + 1'b1;
        else if (dec && !inc && cnt_q[v] != '0) cnt_q[v] <= cnt_q[v] - 1'b1;
        if (smp_i && rd_vc_i == VC_W'(v)) ref_q[v] <= cnt_q[v];
      end
    end

    assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cnt_q[v]) <= Q_DEPTH);
    assert_deq_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec && !inc && cnt_q[v] == '0) |=> cnt_q[v] == '0);
    assert_net_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc && dec) |=> $stable(cnt_q[v]));
  end

  assign cnt_o  = cnt_q[rd_vc_i];
  assign ref_o  = ref_q[rd_vc_i];
  assign full_o = int'(cnt_q[rd_vc_i]) >= Q_DEPTH;
endmodule

// File: rtl/dqi_ingress.sv
module dqi_ingress
  import dqi_pkg::*;
#(
  parameter int NUM_VC  = 16,
  parameter int QL_W    = 15,
  parameter int Q_DEPTH = (1 << QL_W) - 1,
  localparam int VC_W   = $clog2(NUM_VC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [7:0]      in_data_i,
  input  logic [VC_W-1:0] in_vc_i,
  output logic            ready_o,
  input  logic            deq_i,
  input  logic [VC_W-1:0] deq_vc_i,
  output logic            out_valid_o,
  output logic            out_sop_o,
  output logic            out_eop_o,
  output logic [7:0]      out_data_o,
  output logic [VC_W-1:0] out_vc_o,
  output logic            out_fb_o
);
  st_e             state_q;
  idx_t            rx_idx_q, tx_idx_q;
  logic [VC_W-1:0] cell_vc_q;
  logic            is_rm_q, dir_q, mod_q, fb_q;
  logic [9:0]      crc_field_q, crc_rx_q, crc_tx_q;
  logic            out_valid_q, out_sop_q, out_eop_q, out_fb_q;
  logic [7:0]      out_data_q;
  logic [VC_W-1:0] out_vc_q;

  logic            acc, in_dec, rm_ok, bwd, fwd, keep, enq, patch;
  logic [QL_W-1:0] cnt, refv;
  logic            full;
  logic [QL_W:0]   diff;
  logic [15:0]     delta;
  logic [7:0]      rd_byte, tx_byte;

  assign ready_o = (state_q == ST_RX) && !out_valid_q;
  assign acc     = in_valid_i && ready_o;
  assign in_dec  = state_q == ST_DEC;

  // decision on a fully buffered cell
  assign rm_ok = is_rm_q && (crc_rx_q == crc_field_q);
  assign bwd   = rm_ok && dir_q;
  assign fwd   = rm_ok && !dir_q;
  assign keep  = bwd || !full;
  assign enq   = in_dec && !bwd && !full;
  assign patch = in_dec && fwd && !full;
  assign diff  = {1'b0, cnt} - {1'b0, refv};
  assign delta = 16'($signed(diff));

  dqi_vc_counters #(.NUM_VC(NUM_VC), .QL_W(QL_W), .Q_DEPTH(Q_DEPTH)) i_cnt (
    .clk_i, .rst_ni,
    .enq_i   (enq),
    .smp_i   (patch),
    .rd_vc_i (cell_vc_q),
    .deq_i, .deq_vc_i,
    .cnt_o   (cnt),
    .ref_o   (refv),
    .full_o  (full)
  );

  dqi_cell_buf i_buf (
    .clk_i,
    .wr_en_i      (acc),
    .wr_idx_i     (rx_idx_q),
    .wr_data_i    (in_data_i),
    .patch_en_i   (patch),
    .patch_word_i (delta),
    .rd_idx_i     (tx_idx_q),
    .rd_data_o    (rd_byte)
  );

  always_comb begin
    tx_byte = rd_byte;
    if (mod_q && tx_idx_q == idx_t'(CRC_HI)) tx_byte = {rd_byte[7:2], crc_tx_q[9:8]};
    if (mod_q && tx_idx_q == idx_t'(CRC_LO)) tx_byte = crc_tx_q[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RX;
      rx_idx_q    <= '0;
      tx_idx_q    <= '0;
      cell_vc_q   <= '0;
      is_rm_q     <= 1'b0;
      dir_q       <= 1'b0;
      mod_q       <= 1'b0;
      fb_q        <= 1'b0;
      crc_field_q <= '0;
      crc_rx_q    <= '0;
      crc_tx_q    <= '0;
      out_valid_q <= 1'b0;
      out_sop_q   <= 1'b0;
      out_eop_q   <= 1'b0;
      out_fb_q    <= 1'b0;
      out_data_q  <= '0;
      out_vc_q    <= '0;
    end else begin
      out_valid_q <= 1'b0;
      unique case (state_q)
        ST_RX: if (acc) begin
          if (rx_idx_q == '0) begin
            cell_vc_q <= in_vc_i;
            crc_rx_q  <= '0;
          end
          if (rx_idx_q == idx_t'(PTI_BYTE)) is_rm_q <= in_data_i[3:1] == PTI_RM;
          if (rx_idx_q == idx_t'(DIR_BYTE)) dir_q <= in_data_i[7];
          if (rx_idx_q >= idx_t'(CRC_FIRST) && rx_idx_q <= idx_t'(CRC_LAST))
            crc_rx_q <= crc10_byte(crc_rx_q, in_data_i);
          if (rx_idx_q == idx_t'(CRC_HI)) crc_field_q[9:8] <= in_data_i[1:0];
          if (rx_idx_q == idx_t'(CRC_LO)) begin
            crc_field_q[7:0] <= in_data_i;
            rx_idx_q         <= '0;
            state_q          <= ST_DEC;
          end else begin
            rx_idx_q <= rx_idx_q + 1'b1;
          end
        end
        ST_DEC: begin
          mod_q    <= patch;
          fb_q     <= bwd;
          tx_idx_q <= '0;
          crc_tx_q <= '0;
          state_q  <= keep ? ST_TX : ST_RX;
        end
        ST_TX: begin
          out_valid_q <= 1'b1;
          out_sop_q   <= tx_idx_q == '0;
          out_eop_q   <= tx_idx_q == idx_t'(CRC_LO);
          out_data_q  <= tx_byte;
          out_vc_q    <= cell_vc_q;
          out_fb_q    <= fb_q;
          if (tx_idx_q >= idx_t'(CRC_FIRST) && tx_idx_q <= idx_t'(CRC_LAST))
            crc_tx_q <= crc10_byte(crc_tx_q, rd_byte);
          if (tx_idx_q == idx_t'(CRC_LO)) state_q <= ST_RX;
          tx_idx_q <= tx_idx_q + 1'b1;
        end
        default: state_q <= ST_RX;
      endcase
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_sop_o   = out_sop_q;
  assign out_eop_o   = out_eop_q;
  assign out_data_o  = out_data_q;
  assign out_vc_o    = out_vc_q;
  assign out_fb_o    = out_fb_q;

  assert_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !ready_o);
  assert_sop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_sop_o);
  assert_eop_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eop_o) |=> !out_valid_o);
  assert_drop_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_dec && full && !bwd) |=> (!out_valid_o && ready_o));
  assert_fb_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_dec && bwd) |=> (state_q == ST_TX));
endmodule

// File: tb/test_dqi_ingress.sv
module test_dqi_ingress;
  localparam int CLK_PERIOD = 10;
  localparam int NVC   = 4;
  localparam int QD    = 6;
  localparam int VCW   = 2;
  localparam int WATCHDOG = 100000;

  typedef struct packed {
    logic [423:0]   data;
    logic [VCW-1:0] vc;
    logic           fb;
  } exp_t;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           in_valid_i = 1'b0;
  logic [7:0]     in_data_i = '0;
  logic [VCW-1:0] in_vc_i = '0;
  logic           ready_o;
  logic           deq_i = 1'b0;
  logic [VCW-1:0] deq_vc_i = '0;
  logic           out_valid_o, out_sop_o, out_eop_o, out_fb_o;
  logic [7:0]     out_data_o;
  logic [VCW-1:0] out_vc_o;

  int compared = 0;
  int mismatched = 0;
  int m_cnt [NVC];
  int m_ref [NVC];
  int seed = 0;
  bit finished = 1'b0;
  logic [7:0] cb [53];
  exp_t  exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dqi_ingress #(.NUM_VC(NVC), .QL_W(15), .Q_DEPTH(QD)) i_dqi_ingress (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_vc_i, .ready_o,
    .deq_i, .deq_vc_i, .out_valid_o, .out_sop_o, .out_eop_o,
    .out_data_o, .out_vc_o, .out_fb_o
  );

  function automatic logic [9:0] ref_crc(input logic [7:0] c [53]);
    logic [9:0] r = '0;
    for (int k = 5; k <= 50; k++)
      for (int b = 7; b >= 0; b--) begin
        logic top;
        top = r[9] ^ c[k][b];
        r = r << 1;
        if (top) r = r ^ 10'h233;
      end
    return r;
  endfunction

  function automatic logic [423:0] pack_cell(input logic [7:0] c [53]);
    logic [423:0] v;
    for (int k = 0; k < 53; k++) v[k*8 +: 8] = c[k];
    return v;
  endfunction

  task automatic do_deq(input int vc);
    @(negedge clk_i);
    deq_i = 1'b1; deq_vc_i = VCW'(vc);
    if (m_cnt[vc] > 0) m_cnt[vc]--;
    @(negedge clk_i);
    deq_i = 1'b0;
  endtask

  // kind: 0 data, 1 forward RM, 2 backward RM, 3 forward RM with bad CRC
  task automatic send_cell(input int vc, input int kind, input bit deq_same, input string tag);
    logic [9:0] c;
    logic [7:0] ec [53];
    exp_t e;
    int d;
    seed++;
    cb[0] = 8'h00; cb[1] = 8'h10 + 8'(vc); cb[2] = 8'h20; cb[4] = 8'h55;
    cb[3] = (kind != 0) ? 8'h0C : 8'h02;
    cb[5] = 8'h01;
    cb[6] = (kind == 2) ? 8'h80 : 8'h00;
    for (int k = 7; k <= 20; k++) cb[k] = 8'(k * 7 + seed * 13);
    for (int k = 21; k <= 50; k++) cb[k] = 8'h6A;
    c = ref_crc(cb);
    cb[51] = {6'b110100, c[9:8]};
    cb[52] = c[7:0];
    if (kind == 3) cb[52] = cb[52] ^ 8'h01;
    // reference model
    ec = cb;
    if (kind == 2) begin
      e.data = pack_cell(ec); e.vc = VCW'(vc); e.fb = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
    end else if (m_cnt[vc] >= QD) begin
      // dropped: no output, nothing changes
    end else begin
      if (kind == 1) begin
        d = m_cnt[vc] - m_ref[vc];
        ec[21] = 8'(d >> 8);
        ec[22] = 8'(d);
        c = ref_crc(ec);
        ec[51] = {ec[51][7:2], c[9:8]};
        ec[52] = c[7:0];
        m_ref[vc] = m_cnt[vc];
      end
      m_cnt[vc]++;
      e.data = pack_cell(ec); e.vc = VCW'(vc); e.fb = 1'b0;
      exp_q.push_back(e); tag_q.push_back(tag);
    end
    if (deq_same && kind != 2 && m_cnt[vc] > 0) m_cnt[vc]--;
    // drive
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    for (int k = 0; k < 53; k++) begin
      in_valid_i = 1'b1; in_data_i = cb[k]; in_vc_i = VCW'(vc);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    if (deq_same) begin
      deq_i = 1'b1; deq_vc_i = VCW'(vc);
      @(negedge clk_i);
      deq_i = 1'b0;
    end
    while (!ready_o) @(negedge clk_i);
  endtask

  // monitor
  logic [423:0]   got;
  int             mi = 0;
  logic [VCW-1:0] got_vc;
  logic           got_fb;
  bit             frame_bad = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (out_sop_o) begin
        mi = 0; frame_bad = 1'b0; got_vc = out_vc_o; got_fb = out_fb_o;
      end
      if (ready_o) frame_bad = 1'b1;
      if (mi < 53) got[mi*8 +: 8] = out_data_o;
      if (out_eop_o) begin
        exp_t e;
        string t;
        compared++;
        if (mi != 52 || frame_bad) begin
          mismatched++;
          $display("FAIL R1: framing eop index %0d exp 52, ready during output %0d exp 0", mi, frame_bad);
        end
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL R8: unexpected cell vc=%0d got %h exp none", got_vc, got);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (got != e.data || got_vc != e.vc || got_fb != e.fb) begin
            mismatched++;
            $display("FAIL %s: vc got %0d exp %0d fb got %0d exp %0d data got %h exp %h",
                     t, got_vc, e.vc, got_fb, e.fb, got, e.data);
          end
        end
      end
      mi++;
    end
  end

  initial begin : watchdog
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk_i);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung, got no end exp end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NVC; v++) begin m_cnt[v] = 0; m_ref[v] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compared++;
    if (ready_o !== 1'b1 || out_valid_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R11: ready got %b exp 1, out_valid got %b exp 0", ready_o, out_valid_o);
    end
    send_cell(0, 0, 0, "R3");          // data passthrough
    send_cell(0, 1, 0, "R4_R6");       // delta +1
    send_cell(0, 0, 0, "R3");
    send_cell(0, 0, 0, "R3");
    send_cell(0, 1, 0, "R5");          // delta +3
    do_deq(0); do_deq(0); do_deq(0);
    send_cell(0, 1, 0, "R4");          // delta -2
    send_cell(0, 2, 0, "R7");          // backward, not counted
    send_cell(0, 1, 0, "R7");          // delta +1
    send_cell(1, 3, 0, "R2");          // bad CRC -> data
    send_cell(1, 1, 0, "R2");          // delta +1 shows it was counted
    for (int k = 0; k < 4; k++) send_cell(1, 0, 0, "R3");
    send_cell(1, 0, 0, "R8");          // dropped
    send_cell(1, 1, 0, "R8");          // dropped, ref kept
    send_cell(1, 2, 0, "R7");          // backward never dropped
    do_deq(1);
    send_cell(1, 1, 0, "R8");          // delta +4
    do_deq(2); do_deq(2);
    send_cell(2, 1, 0, "R10");         // delta 0
    send_cell(2, 0, 0, "R10");
    send_cell(2, 1, 0, "R10");         // delta +2
    send_cell(3, 0, 0, "R9");
    send_cell(3, 0, 1, "R9");          // enq and deq same edge
    send_cell(3, 1, 0, "R9");          // delta +1
    send_cell(3, 1, 1, "R9");          // delta +1 with deq on decision edge
    send_cell(3, 1, 0, "R9");          // delta 0
    repeat (80) @(negedge clk_i);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R1: missing cells got %0d left exp 0", exp_q.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule